// File: doc/BRIEF.md
# Retriggerable Down-Counting Timer with Control/Status Register

The block is a down-counting timer that refills itself from a programmable preset each time it runs out. It advances only on a timer clock. That clock is a single-cycle enable strobe `tick` in the system clock domain, so the whole block runs on one clock. A small byte-wide register port gives software three things:
- a control/status byte,
- the preset value, split into bytes,
- a read-only view of the live count.

Software can ask for a restart. The request waits for the next timer tick, reloads the counter from the preset, and then clears itself. A terminal-count flag records that the counter reached zero. Reading the control/status byte clears that flag.

The sequencing lives in a two-state controller.
- State `ST_LOAD` means the counter must be refilled on the next tick. The block enters it after reset and after the count reaches zero.
- State `ST_COUNT` means the counter is decrementing.

The transitions are as follows.
- `ST_LOAD` to `ST_COUNT` happens on a tick that loads a non-zero preset.
- `ST_LOAD` to `ST_LOAD` happens on a tick that loads a zero preset.
- `ST_COUNT` to `ST_LOAD` happens on a tick that takes the count from 1 to 0.
- `ST_COUNT` reloads and stays in `ST_COUNT` on a tick with a restart pending, when the preset is non-zero.
- Without a tick, the state holds.

The register map uses byte addresses:
- 0: control/status. Bit 0 is restart-pending (write 1 to request). Bit 1 is the terminal-count flag.
- 1 to NB: the preset bytes, least significant first.
- NB+1 to 2·NB: the count bytes, least significant first.

NB is CNT_W/8 rounded up.

Top module: `retrig_timer`

## Requirements
- R1: After reset, the control/status byte reads 0x00, every count byte reads 0x00, the preset reads PRESET_RST and the controller is in `ST_LOAD`.
- R2: In `ST_COUNT`, with no restart pending, each tick lowers the count by exactly one. Without a tick the count never changes.
- R3: A tick that leaves the count at zero sets bit 1 of the control/status byte. It also raises `tc_pulse` for exactly the following system cycle.
- R4: On the first tick in `ST_LOAD` (after reset, or after the count reached zero), the counter is filled from the preset. Counting then carries on with no software action. A zero preset reaches terminal count again on every load.
- R5: Writing a byte with bit 0 = 1 to address 0 sets restart-pending, and it reads back as 1. The next tick loads the preset into the counter and clears the bit.
- R6: Writing bit 0 = 0 to address 0 neither requests nor cancels a restart, and leaves counting unchanged.
- R7: Bit 1 of the control/status byte is read-only. Writing to address 0 can neither set it nor clear it.
- R8: A read of address 0 returns the current flag and clears bit 1 after that cycle.
- R9: If a read of address 0 falls in the same cycle as a tick that reaches zero, the read returns the old value and the flag ends up set.
- R10: Bits 7..2 of the control/status byte, and preset bits at or above CNT_W, always read 0. Writes to them are discarded.
- R11: The preset bytes can be written and read back one at a time. A new preset does not disturb the running count and is used from the next load onwards.
- R12: Addresses above 2·NB read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timer clock strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (has side effects at address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high; 0 otherwise |
| tc_pulse | output | 1 | One-cycle pulse after the count reaches zero |

## Verification
The bench builds the block with CNT_W = 12, ADDR_W = 3 and PRESET_RST = 5. With a 12-bit counter the upper preset byte is only half populated, so the bench can show that bits 7..4 of that byte are discarded and read as zero. It can also show that a preset with a non-zero upper byte reloads correctly into both count bytes. The small reset preset lets a full count-down, terminal count and automatic reload happen within a handful of ticks. A short preset of 1, and a preset of 0, set up the case of a flag-clearing read colliding with a new terminal count, and the case of terminal count on every load.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

    typedef enum logic [0:0] {
        ST_LOAD  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;

    localparam int CSR_ADDR    = 0;
    localparam int RESTART_BIT = 0;
    localparam int TC_BIT      = 1;

    function automatic int byte_count(input int width);
        return (width + 7) / 8;
    endfunction

    // Mask of the preset bits that exist inside byte idx of a width-bit value
    function automatic logic [7:0] byte_mask(input int width, input int idx);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b] = ((8 * idx + b) < width);
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_core.sv
module tmr_core
    import rtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output tmr_state_e       state,
    output logic             tc_event
);

    tmr_state_e       nxt_state;
    logic [CNT_W-1:0] nxt_count;
    logic             do_load;

    // state and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOAD;
            count <= '0;
        end else begin
            state <= nxt_state;
            count <= nxt_count;
        end
    end

    // next state, next count and terminal-count event
    always_comb begin
        nxt_state = state;
        nxt_count = count;
        do_load   = 1'b0;
        if (tick) begin
            unique case (state)
                ST_LOAD: begin
                    do_load = 1'b1;
                end
                ST_COUNT: begin
                    if (restart) begin
                        do_load = 1'b1;
                    end else begin
                        nxt_count = count - CNT_W'(1);
                        if (count == CNT_W'(1)) begin
                            nxt_state = ST_LOAD;
                        end
                    end
                end
                default: begin
                    do_load = 1'b1;
                end
            endcase
            if (do_load) begin
                nxt_count = preset;
                nxt_state = (preset == '0) ? ST_LOAD : ST_COUNT;
            end
        end
        tc_event = tick && (nxt_count == '0);
    end

endmodule

// File: rtl/tmr_csr.sv
module tmr_csr
    import rtmr_pkg::*;
#(
    parameter int             CNT_W      = 16,
    parameter int             NB         = 2,
    parameter logic [CNT_W-1:0] PRESET_RST = CNT_W'(15)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_wr,
    input  logic            csr_rd,
    input  logic [7:0]      wdata,
    input  logic [NB-1:0]   preset_wr,
    input  logic            tick,
    input  logic            tc_event,
    output logic            restart_pend,
    output logic            tc_flag,
    output logic            tc_pulse,
    output logic [NB*8-1:0] preset_q
);

    localparam int PW = NB * 8;

    logic set_req;

    assign set_req = csr_wr && wdata[RESTART_BIT];

    // restart request: set by a write of 1, consumed by the next tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_pend <= 1'b0;
        end else begin
            restart_pend <= (restart_pend && !tick) || set_req;
        end
    end

    // terminal-count flag: a new event outranks a clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_flag  <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            tc_pulse <= tc_event;
            if (tc_event) begin
                tc_flag <= 1'b1;
            end else if (csr_rd) begin
                tc_flag <= 1'b0;
            end
        end
    end

    // preset bytes, with bits beyond CNT_W held at zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= PW'(PRESET_RST);
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (preset_wr[i]) begin
                    preset_q[i*8 +: 8] <= wdata & byte_mask(CNT_W, i);
                end
            end
        end
    end

endmodule

// File: rtl/tmr_bus.sv
module tmr_bus
    import rtmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NB     = 2,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              restart_pend,
    input  logic              tc_flag,
    input  logic [NB*8-1:0]   preset_q,
    input  logic [CNT_W-1:0]  count,
    output logic              csr_wr,
    output logic              csr_rd,
    output logic [NB-1:0]     preset_wr,
    output logic [7:0]        rdata
);

    localparam int PBASE = 1;
    localparam int CBASE = 1 + NB;

    logic [NB*8-1:0] cnt_pad;
    logic            hit_csr;

    assign cnt_pad = (NB*8)'(count);
    assign hit_csr = (addr == ADDR_W'(CSR_ADDR));
    assign csr_wr  = wr && hit_csr;
    assign csr_rd  = rd && hit_csr;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_pwr
            assign preset_wr[g] = wr && (addr == ADDR_W'(PBASE + g));
        end
    endgenerate

    always_comb begin
        rdata = 8'h00;
        if (rd) begin
            if (hit_csr) begin
                rdata[RESTART_BIT] = restart_pend;
                rdata[TC_BIT]      = tc_flag;
            end
            for (int i = 0; i < NB; i++) begin
                if (addr == ADDR_W'(PBASE + i)) begin
                    rdata = preset_q[i*8 +: 8];
                end
                if (addr == ADDR_W'(CBASE + i)) begin
                    rdata = cnt_pad[i*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/retrig_timer.sv
module retrig_timer
    import rtmr_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               ADDR_W     = 3,
    parameter logic [CNT_W-1:0] PRESET_RST = CNT_W'(15)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              tc_pulse
);

    localparam int NB = byte_count(CNT_W);

    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] preset_w;
    logic [NB*8-1:0]  preset_q_w;
    tmr_state_e       state_w;
    logic             tc_event_w;
    logic             restart_w;
    logic             tc_flag_w;
    logic             csr_wr_w;
    logic             csr_rd_w;
    logic [NB-1:0]    preset_wr_w;

    assign preset_w = preset_q_w[CNT_W-1:0];

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart_w),
        .preset   (preset_w),
        .count    (count_w),
        .state    (state_w),
        .tc_event (tc_event_w)
    );

    tmr_csr #(.CNT_W(CNT_W), .NB(NB), .PRESET_RST(PRESET_RST)) u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .csr_wr       (csr_wr_w),
        .csr_rd       (csr_rd_w),
        .wdata        (bus_wdata),
        .preset_wr    (preset_wr_w),
        .tick         (tick),
        .tc_event     (tc_event_w),
        .restart_pend (restart_w),
        .tc_flag      (tc_flag_w),
        .tc_pulse     (tc_pulse),
        .preset_q     (preset_q_w)
    );

    tmr_bus #(.CNT_W(CNT_W), .NB(NB), .ADDR_W(ADDR_W)) u_bus (
        .addr         (bus_addr),
        .wr           (bus_wr),
        .rd           (bus_rd),
        .restart_pend (restart_w),
        .tc_flag      (tc_flag_w),
        .preset_q     (preset_q_w),
        .count        (count_w),
        .csr_wr       (csr_wr_w),
        .csr_rd       (csr_rd_w),
        .preset_wr    (preset_wr_w),
        .rdata        (bus_rdata)
    );

endmodule

// File: rtl/rt_checker.sv
module rt_checker
    import rtmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              wdata0,
    input logic [7:0]        bus_rdata,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  preset,
    input tmr_state_e        state,
    input logic              restart_pend,
    input logic              tc_flag,
    input logic              tc_pulse
);

    logic at_csr;
    assign at_csr = (bus_addr == ADDR_W'(CSR_ADDR));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_COUNT && !restart_pend) |=> count == $past(count) - CNT_W'(1));

    assert_tc_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> count == '0);

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_LOAD) |=> count == $past(preset));

    assert_restart_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart_pend) |=> count == $past(preset));

    assert_restart_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart_pend && !(bus_wr && at_csr && wdata0)) |=> !restart_pend);

    assert_tc_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_flag) |-> tc_pulse);

    assert_tc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_csr) |=> (!tc_flag || tc_pulse));

    assert_tc_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> tc_flag);

    assert_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_csr) |-> bus_rdata[7:2] == 6'd0);

endmodule

bind retrig_timer rt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .wdata0       (bus_wdata[0]),
    .bus_rdata    (bus_rdata),
    .count        (count_w),
    .preset       (preset_w),
    .state        (state_w),
    .restart_pend (restart_w),
    .tc_flag      (tc_flag_w),
    .tc_pulse     (tc_pulse)
);

// File: tb/tb_retrig_timer.sv
module tb_retrig_timer;

    localparam int CNT_W  = 12;
    localparam int ADDR_W = 3;
    localparam int NV     = 44;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;

    // {op, addr, data/expected, requirement}
    localparam logic [16:0] VEC [NV] = '{
        {OP_RD, 3'd0, 8'h00, 4'd1},  // R1 csr
        {OP_RD, 3'd1, 8'h05, 4'd1},  // R1 preset lo
        {OP_RD, 3'd2, 8'h00, 4'd1},  // R1 preset hi
        {OP_RD, 3'd3, 8'h00, 4'd1},  // R1 count lo
        {OP_RD, 3'd4, 8'h00, 4'd1},  // R1 count hi
        {OP_TK, 3'd0, 8'h00, 4'd4},  // R4 first load
        {OP_RD, 3'd3, 8'h05, 4'd4},
        {OP_TK, 3'd0, 8'h00, 4'd2},  // R2
        {OP_RD, 3'd3, 8'h04, 4'd2},
        {OP_RD, 3'd3, 8'h04, 4'd2},  // R2 hold without tick
        {OP_TK, 3'd0, 8'h00, 4'd2},
        {OP_TK, 3'd0, 8'h00, 4'd2},
        {OP_TK, 3'd0, 8'h00, 4'd2},
        {OP_RD, 3'd3, 8'h01, 4'd2},
        {OP_TK, 3'd0, 8'h00, 4'd3},  // R3 reach zero
        {OP_RD, 3'd0, 8'h02, 4'd3},
        {OP_RD, 3'd0, 8'h00, 4'd8},  // R8 cleared by read
        {OP_RD, 3'd3, 8'h00, 4'd3},
        {OP_TK, 3'd0, 8'h00, 4'd4},  // R4 auto reload
        {OP_RD, 3'd3, 8'h05, 4'd4},
        {OP_WR, 3'd1, 8'h34, 4'd11}, // R11
        {OP_WR, 3'd2, 8'hF2, 4'd10}, // R10 upper bits dropped
        {OP_RD, 3'd2, 8'h02, 4'd10},
        {OP_RD, 3'd1, 8'h34, 4'd11},
        {OP_RD, 3'd3, 8'h05, 4'd11}, // R11 running count untouched
        {OP_WR, 3'd0, 8'h01, 4'd5},  // R5
        {OP_RD, 3'd0, 8'h01, 4'd5},
        {OP_TK, 3'd0, 8'h00, 4'd5},
        {OP_RD, 3'd0, 8'h00, 4'd5},
        {OP_RD, 3'd3, 8'h34, 4'd5},
        {OP_RD, 3'd4, 8'h02, 4'd5},
        {OP_WR, 3'd0, 8'h00, 4'd6},  // R6
        {OP_RD, 3'd0, 8'h00, 4'd6},
        {OP_TK, 3'd0, 8'h00, 4'd6},
        {OP_RD, 3'd3, 8'h33, 4'd6},
        {OP_WR, 3'd0, 8'hFC, 4'd7},  // R7 and R10
        {OP_RD, 3'd0, 8'h00, 4'd7},
        {OP_RD, 3'd3, 8'h33, 4'd10},
        {OP_RD, 3'd5, 8'h00, 4'd12}, // R12
        {OP_RD, 3'd7, 8'h00, 4'd12},
        {OP_WR, 3'd6, 8'hFF, 4'd12},
        {OP_RD, 3'd1, 8'h34, 4'd12},
        {OP_RD, 3'd2, 8'h02, 4'd12},
        {OP_RD, 3'd0, 8'h00, 4'd12}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              tc_pulse;
    int                n_chk = 0;
    int                n_fail = 0;

    always #4 clk = ~clk;

    retrig_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PRESET_RST(CNT_W'(5))) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tc_pulse  (tc_pulse)
    );

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input int req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(req, bus_rdata, e);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i][16:15])
                OP_WR:   do_wr(VEC[i][14:12], VEC[i][11:4]);
                OP_RD:   do_rd(VEC[i][14:12], VEC[i][11:4], int'(VEC[i][3:0]));
                default: do_tick();
            endcase
        end

        // R3 pulse width and R7 write cannot clear flag, preset of 1
        do_wr(3'd1, 8'h01);
        do_wr(3'd2, 8'h00);
        do_wr(3'd0, 8'h01);
        do_tick();
        do_rd(3'd3, 8'h01, 11);          // R11 new preset used at load
        do_tick();
        check(3, {7'd0, tc_pulse}, 8'h01); // R3 pulse after reaching zero
        @(posedge clk); #1;
        check(3, {7'd0, tc_pulse}, 8'h00); // R3 pulse lasts one cycle
        do_wr(3'd0, 8'h00);
        do_rd(3'd0, 8'h02, 7);           // R7 write left flag set
        do_rd(3'd0, 8'h00, 8);           // R8

        // R9 clearing read collides with new terminal count
        do_tick();                       // reload to 1
        @(negedge clk);
        bus_addr = 3'd0; bus_rd = 1'b1; tick = 1'b1;
        #1 check(9, bus_rdata, 8'h00);   // R9 read returns old value
        @(posedge clk); #1;
        bus_rd = 1'b0; tick = 1'b0;
        do_rd(3'd0, 8'h02, 9);           // R9 flag stays set
        do_rd(3'd0, 8'h00, 8);

        // R4 zero preset: terminal count on every load
        do_wr(3'd1, 8'h00);
        do_tick();
        do_rd(3'd0, 8'h02, 4);           // R4
        do_tick();
        do_rd(3'd0, 8'h02, 4);           // R4 again after clearing read
        do_rd(3'd3, 8'h00, 4);

        // R1 reset in mid-run
        do_wr(3'd1, 8'h77);
        do_wr(3'd0, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_rd(3'd1, 8'h05, 1);           // R1 preset restored
        do_rd(3'd0, 8'h00, 1);           // R1 restart and flag cleared
        do_rd(3'd3, 8'h00, 1);
        do_tick();
        do_rd(3'd3, 8'h05, 4);           // R4 load after reset

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule